// File: doc/BRIEF.md
# Priority-Resolved Pad Function Multiplexer

This block sits between a bank of physical pads and a set of peripheral function signals. Every pad has its own configuration word. A select field in that word picks the function whose output value and output enable reach the pad. On the return path, each function input takes the level of a pad configured onto it. The input path is purely combinational, so pad levels reach the functions within the same cycle. Configuration changes take effect at the next clock edge.

Each function has a fixed kind, set by a parameter: output-only, input-only, or bidirectional bus. The kind decides how the pad's output enable is produced. A bus function drives the pad direction itself. It also supplies the pad's attribute code (pull and drive strength) from a constant table, so no manual pad setup is needed.

If several pads are configured onto one function input, a fixed priority picks exactly one of them. Conflicting pad levels are therefore never merged.

Top module: `padmux_top`

## Requirements
- R1: After reset every configuration word is zero. Every pad reads back 0, every pad output enable is 0, every pad attribute is 0, and every function input reads 1.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the pad addressed by `cfg_addr` at the next rising clock edge. Bits [SEL_W-1:0] hold the function select and the bits above them hold the pad attribute register. `cfg_rdata` returns the addressed pad's word combinationally. Writes to addresses at or above NUM_PADS change nothing, and reads of those addresses return 0.
- R3: A pad whose select is 0, or greater than NUM_FUNCS, drives `pad_out` 0 and `pad_oe` 0. Its attribute output is its own attribute register.
- R4: A pad with select value k (1..NUM_FUNCS) drives `pad_out` from `fn_out[k-1]`. Any number of pads may select the same function, and each one replicates its output.
- R5: The pad output enable depends on the kind of the selected function. The kind codes are 0 = output-only, 1 = input-only and 2 = bus, and the defaults are functions 0 and 3 output-only, function 1 input-only, and functions 2 and 4 bus. Output-only forces the enable to 1, input-only forces it to 0, and bus passes `fn_oe[k-1]` through.
- R6: `fn_in[f]` equals `pad_in` of the lowest-numbered pad whose select is f+1.
- R7: `fn_in[f]` reads 1 when no pad selects function f.
- R8: When a pad selects a bus function, `pad_attr` for that pad is that function's constant code. The default codes are 3'b110 for function 2 and 3'b101 for function 4. Otherwise `pad_attr` is the pad's attribute register.
- R9: A change on `pad_in` appears on `fn_in` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Pad index for both write and read |
| cfg_wdata | input | CFG_W | Attribute field above the select field |
| cfg_rdata | output | CFG_W | Configuration word of the addressed pad |
| pad_in | input | NUM_PADS | Level sampled at each pad |
| pad_out | output | NUM_PADS | Value driven onto each pad |
| pad_oe | output | NUM_PADS | Output enable for each pad |
| pad_attr | output | NUM_PADS*ATTR_W | Pull/drive code per pad, pad p at bits [p*ATTR_W +: ATTR_W] |
| fn_out | input | NUM_FUNCS | Output value from each function |
| fn_oe | input | NUM_FUNCS | Direction request from each function, used by bus kinds |
| fn_in | output | NUM_FUNCS | Input value delivered to each function |

## Verification
Some properties are checked on every cycle by assertions. A write to an in-range pad must be visible in the readback one cycle later. At most one pad wins a function input, and that pad has no lower-numbered competitor. An unclaimed function input sits at 1. An unused pad stays undriven. Each selected pad's enable, value and attribute follow the kind of its function.

The bench sweeps every select combination on four pads, including the out-of-range codes, with all pad input patterns. It checks the reset state, ignored out-of-range writes, and the absence of any clock in the input path. Only these scenarios can show them.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

   // Kind of a peripheral function, decides who owns the pad direction
   typedef enum logic [1:0] {
      FK_OUT = 2'd0,
      FK_IN  = 2'd1,
      FK_BUS = 2'd2
   } fkind_e;

endpackage

// File: rtl/padmux_cfg_regs.sv
module padmux_cfg_regs #(
   parameter  int NUM_PADS = 4,
   parameter  int SEL_W    = 3,
   parameter  int ATTR_W   = 3,
   parameter  int ADDR_W   = 3,
   localparam int CFG_W    = SEL_W + ATTR_W
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [ADDR_W-1:0]                   addr,
   input  logic [CFG_W-1:0]                    wr_data,
   output logic [CFG_W-1:0]                    rd_data,
   output logic [NUM_PADS-1:0][SEL_W-1:0]      sel_q,
   output logic [NUM_PADS-1:0][ATTR_W-1:0]     attr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         attr_q <= '0;
      end else if (wr_en) begin
         for (int p = 0; p < NUM_PADS; p++) begin
            if (addr == ADDR_W'(p)) begin
               sel_q[p]  <= wr_data[SEL_W-1:0];
               attr_q[p] <= wr_data[CFG_W-1:SEL_W];
            end
         end
      end
   end

   // Out-of-range addresses fall through and read as zero
   always_comb begin
      rd_data = '0;
      for (int p = 0; p < NUM_PADS; p++) begin
         if (addr == ADDR_W'(p)) rd_data = {attr_q[p], sel_q[p]};
      end
   end

   // R2: an in-range write is visible through readback one cycle later
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(addr) < NUM_PADS)) |=>
         ((addr != $past(addr)) || (rd_data == $past(wr_data))));

endmodule

// File: rtl/padmux_pad_lane.sv
module padmux_pad_lane #(
   parameter int                            NUM_FUNCS  = 5,
   parameter int                            SEL_W      = 3,
   parameter int                            ATTR_W     = 3,
   parameter logic [2*NUM_FUNCS-1:0]        FUNC_KINDS = '0,
   parameter logic [ATTR_W*NUM_FUNCS-1:0]   BUS_ATTR   = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SEL_W-1:0]      sel,
   input  logic [ATTR_W-1:0]     attr_reg,
   input  logic [NUM_FUNCS-1:0]  fn_out,
   input  logic [NUM_FUNCS-1:0]  fn_oe,
   output logic                  pad_out,
   output logic                  pad_oe,
   output logic [ATTR_W-1:0]     pad_attr,
   output logic [NUM_FUNCS-1:0]  fn_match
);
   import padmux_pkg::*;

   fkind_e              kind_tab [NUM_FUNCS];
   logic [ATTR_W-1:0]   attr_tab [NUM_FUNCS];

   for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
      assign fn_match[f] = (sel == SEL_W'(f + 1));
      assign kind_tab[f] = fkind_e'(FUNC_KINDS[2*f +: 2]);
      assign attr_tab[f] = BUS_ATTR[ATTR_W*f +: ATTR_W];

      // R4: a selected function's output value is replicated on the pad
      p_out_replicate_r4: assert property (@(posedge clk) disable iff (!rst_n)
         fn_match[f] |-> (pad_out == fn_out[f]));
      // R5: direction per function kind
      p_oe_out_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (fn_match[f] && kind_tab[f] == FK_OUT) |-> pad_oe);
      p_oe_in_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (fn_match[f] && kind_tab[f] == FK_IN) |-> !pad_oe);
      p_oe_bus_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (fn_match[f] && kind_tab[f] == FK_BUS) |-> (pad_oe == fn_oe[f]));
      // R8: bus functions impose their attribute code
      p_bus_attr_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (fn_match[f] && kind_tab[f] == FK_BUS) |-> (pad_attr == attr_tab[f]));
   end

   always_comb begin
      pad_out  = 1'b0;
      pad_oe   = 1'b0;
      pad_attr = attr_reg;
      for (int f = 0; f < NUM_FUNCS; f++) begin
         if (fn_match[f]) begin
            pad_out = fn_out[f];
            unique case (kind_tab[f])
               FK_OUT:  pad_oe = 1'b1;
               FK_IN:   pad_oe = 1'b0;
               FK_BUS: begin
                  pad_oe   = fn_oe[f];
                  pad_attr = attr_tab[f];
               end
               default: pad_oe = 1'b0;
            endcase
         end
      end
   end

   // R3: a pad with no valid selection stays undriven
   p_unused_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(|fn_match) |-> (!pad_oe && !pad_out && pad_attr == attr_reg));

endmodule

// File: rtl/padmux_in_prio.sv
module padmux_in_prio #(
   parameter int NUM_PADS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PADS-1:0]  pad_sel,
   input  logic [NUM_PADS-1:0]  pad_in,
   output logic                 fn_in
);

   logic [NUM_PADS-1:0] grant;
   logic                found;

   // Lowest-numbered claiming pad wins; the others are masked off
   always_comb begin
      grant = '0;
      found = 1'b0;
      for (int p = 0; p < NUM_PADS; p++) begin
         if (pad_sel[p] && !found) begin
            grant[p] = 1'b1;
            found    = 1'b1;
         end
      end
      fn_in = found ? |(grant & pad_in) : 1'b1;
   end

   // R6: never more than one pad feeds the function input
   p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R7: unclaimed function input idles high
   p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_sel == '0) |-> fn_in);

   for (genvar p = 1; p < NUM_PADS; p++) begin : g_low
      // R6: a granted pad has no lower-numbered competitor
      p_grant_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
         grant[p] |-> (pad_sel[p-1:0] == '0));
   end

endmodule

// File: rtl/padmux_top.sv
module padmux_top #(
   parameter  int                            NUM_PADS   = 4,
   parameter  int                            NUM_FUNCS  = 5,
   parameter  int                            ATTR_W     = 3,
   parameter  logic [2*NUM_FUNCS-1:0]        FUNC_KINDS = 10'b10_00_10_01_00,
   parameter  logic [ATTR_W*NUM_FUNCS-1:0]   BUS_ATTR   = 15'b101_000_110_000_000,
   localparam int                            SEL_W      = $clog2(NUM_FUNCS + 1),
   localparam int                            ADDR_W     = $clog2(NUM_PADS + 1),
   localparam int                            CFG_W      = SEL_W + ATTR_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [ADDR_W-1:0]             cfg_addr,
   input  logic [CFG_W-1:0]              cfg_wdata,
   output logic [CFG_W-1:0]              cfg_rdata,
   input  logic [NUM_PADS-1:0]           pad_in,
   output logic [NUM_PADS-1:0]           pad_out,
   output logic [NUM_PADS-1:0]           pad_oe,
   output logic [NUM_PADS*ATTR_W-1:0]    pad_attr,
   input  logic [NUM_FUNCS-1:0]          fn_out,
   input  logic [NUM_FUNCS-1:0]          fn_oe,
   output logic [NUM_FUNCS-1:0]          fn_in
);

   // Elaboration-time parameter checks
   if (NUM_PADS < 1) begin : g_bad_pads
      $error("padmux_top: NUM_PADS must be at least 1");
   end
   if (NUM_FUNCS < 1) begin : g_bad_funcs
      $error("padmux_top: NUM_FUNCS must be at least 1");
   end
   if (ATTR_W < 1) begin : g_bad_attr
      $error("padmux_top: ATTR_W must be at least 1");
   end
   for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_kind_chk
      if (FUNC_KINDS[2*f +: 2] == 2'b11) begin : g_bad_kind
         $error("padmux_top: reserved function kind code");
      end
   end

   logic [NUM_PADS-1:0][SEL_W-1:0]  sel_q;
   logic [NUM_PADS-1:0][ATTR_W-1:0] attr_q;
   logic [NUM_FUNCS-1:0]            match_row [NUM_PADS];
   logic [NUM_PADS-1:0]             match_col [NUM_FUNCS];

   padmux_cfg_regs #(
      .NUM_PADS (NUM_PADS),
      .SEL_W    (SEL_W),
      .ATTR_W   (ATTR_W),
      .ADDR_W   (ADDR_W)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .addr    (cfg_addr),
      .wr_data (cfg_wdata),
      .rd_data (cfg_rdata),
      .sel_q   (sel_q),
      .attr_q  (attr_q)
   );

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      padmux_pad_lane #(
         .NUM_FUNCS  (NUM_FUNCS),
         .SEL_W      (SEL_W),
         .ATTR_W     (ATTR_W),
         .FUNC_KINDS (FUNC_KINDS),
         .BUS_ATTR   (BUS_ATTR)
      ) i_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (sel_q[p]),
         .attr_reg (attr_q[p]),
         .fn_out   (fn_out),
         .fn_oe    (fn_oe),
         .pad_out  (pad_out[p]),
         .pad_oe   (pad_oe[p]),
         .pad_attr (pad_attr[p*ATTR_W +: ATTR_W]),
         .fn_match (match_row[p])
      );
   end

   for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
      for (genvar p = 0; p < NUM_PADS; p++) begin : g_tr
         assign match_col[f][p] = match_row[p][f];
      end

      padmux_in_prio #(
         .NUM_PADS (NUM_PADS)
      ) i_prio (
         .clk     (clk),
         .rst_n   (rst_n),
         .pad_sel (match_col[f]),
         .pad_in  (pad_in),
         .fn_in   (fn_in[f])
      );
   end

endmodule

// File: tb/test_padmux_top.sv
module test_padmux_top;
   localparam int NP  = 4;
   localparam int NF  = 5;
   localparam int AW  = 3;
   localparam int SW  = 3;
   localparam int ADW = 3;
   localparam int CW  = SW + AW;
   localparam logic [2*NF-1:0] KINDS = 10'b10_00_10_01_00;
   localparam logic [AW*NF-1:0] BATTR = 15'b101_000_110_000_000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [ADW-1:0]    cfg_addr = '0;
   logic [CW-1:0]     cfg_wdata = '0;
   logic [CW-1:0]     cfg_rdata;
   logic [NP-1:0]     pad_in = '0;
   logic [NP-1:0]     pad_out, pad_oe;
   logic [NP*AW-1:0]  pad_attr;
   logic [NF-1:0]     fn_out = '0, fn_oe = '0;
   logic [NF-1:0]     fn_in;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   int sel_m [NP];
   int attr_m [NP];

   always #5 clk = ~clk;

   padmux_top #(
      .NUM_PADS(NP), .NUM_FUNCS(NF), .ATTR_W(AW),
      .FUNC_KINDS(KINDS), .BUS_ATTR(BATTR)
   ) i_padmux_top (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_attr(pad_attr),
      .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [CW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = ADW'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic int kind_of(input int f);
      return int'(KINDS[2*f +: 2]);
   endfunction

   function automatic logic [NF-1:0] exp_fn_in();
      logic [NF-1:0] r;
      for (int f = 0; f < NF; f++) begin
         r[f] = 1'b1;
         for (int p = NP - 1; p >= 0; p--)
            if (sel_m[p] == f + 1) r[f] = pad_in[p];
      end
      return r;
   endfunction

   function automatic logic [NP-1:0] exp_out();
      logic [NP-1:0] r;
      for (int p = 0; p < NP; p++) begin
         int s = sel_m[p];
         r[p] = (s >= 1 && s <= NF) ? fn_out[s-1] : 1'b0;
      end
      return r;
   endfunction

   function automatic logic [NP-1:0] exp_oe();
      logic [NP-1:0] r;
      for (int p = 0; p < NP; p++) begin
         int s = sel_m[p];
         r[p] = 1'b0;
         if (s >= 1 && s <= NF) begin
            case (kind_of(s - 1))
               0: r[p] = 1'b1;
               1: r[p] = 1'b0;
               default: r[p] = fn_oe[s-1];
            endcase
         end
      end
      return r;
   endfunction

   function automatic logic [NP*AW-1:0] exp_attr();
      logic [NP*AW-1:0] r;
      for (int p = 0; p < NP; p++) begin
         int s = sel_m[p];
         if (s >= 1 && s <= NF && kind_of(s - 1) == 2)
            r[p*AW +: AW] = BATTR[AW*(s-1) +: AW];
         else
            r[p*AW +: AW] = AW'(attr_m[p]);
      end
      return r;
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      for (int p = 0; p < NP; p++) begin sel_m[p] = 0; attr_m[p] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         cfg_addr = ADW'(a); #1;
         chk("R1 readback", 32'(cfg_rdata), 32'd0);
      end
      pad_in = 4'b0101; fn_out = '1; fn_oe = '1; #1;
      chk("R1 pad_oe", 32'(pad_oe), 32'd0);
      chk("R1 pad_attr", 32'(pad_attr), 32'd0);
      chk("R1 fn_in idle", 32'(fn_in), 32'h1f);

      // Exhaustive sweep over every select combination (R2..R8)
      for (int c = 0; c < 4096; c++) begin
         for (int p = 0; p < NP; p++) begin
            sel_m[p]  = (c >> (3 * p)) & 7;
            attr_m[p] = (c + 3 * p) & 7;
            wr(p, {AW'(attr_m[p]), SW'(sel_m[p])});
         end
         for (int p = 0; p < NP; p++) begin
            cfg_addr = ADW'(p); #1;
            chk("R2 readback", 32'(cfg_rdata), 32'({AW'(attr_m[p]), SW'(sel_m[p])}));
         end
         for (int v = 0; v < 16; v++) begin
            pad_in = NP'(v);
            fn_out = NF'(v * 3 + c);
            fn_oe  = NF'((v * 7) ^ c);
            #1;
            chk("R6/R7 fn_in", 32'(fn_in), 32'(exp_fn_in()));
            chk("R3/R4 pad_out", 32'(pad_out), 32'(exp_out()));
            chk("R3/R5 pad_oe", 32'(pad_oe), 32'(exp_oe()));
            chk("R8 pad_attr", 32'(pad_attr), 32'(exp_attr()));
         end
      end

      // R2: out-of-range writes change nothing and read as zero
      for (int a = NP; a < 8; a++) wr(a, '1);
      for (int a = 0; a < 8; a++) begin
         cfg_addr = ADW'(a); #1;
         if (a < NP)
            chk("R2 oob write ignored", 32'(cfg_rdata), 32'({AW'(attr_m[a]), SW'(sel_m[a])}));
         else
            chk("R2 oob read zero", 32'(cfg_rdata), 32'd0);
      end

      // R6 priority with conflicting levels; R9 response between clock edges
      sel_m[0] = 0; sel_m[1] = 3; sel_m[2] = 3; sel_m[3] = 3;
      for (int p = 0; p < NP; p++) wr(p, {AW'(attr_m[p]), SW'(sel_m[p])});
      @(negedge clk);
      pad_in = 4'b1100; #1;
      chk("R6 lowest pad wins", 32'(fn_in[2]), 32'd0);
      pad_in = 4'b0010; #1;
      chk("R9 no-clock path", 32'(fn_in[2]), 32'd1);
      chk("R7 unclaimed input", 32'(fn_in[0]), 32'd1);

      done = 1;
      finish_run();
   end
endmodule